// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block turns three independent causes into one clean system reset. A supply-good level from an external comparator, an active-low push-button line and a watchdog serviced by the host all feed it. Reset goes active as soon as any cause appears. It stays active while that cause persists, and it is released only after a recovery interval once every cause has gone. A watchdog expiry does not hold reset by level. It fires a one-cycle trigger, and that trigger starts a full recovery interval of its own.

All time is counted in cycles. The recovery interval and the watchdog period advance only on cycles where the `tick` enable is high, so a slow tick sets the real-time scale. The push-button glitch filter counts raw clock cycles. The supply, push-button and service inputs each pass through a two-flop synchronizer. The service input is watched for edges in either direction. A watchdog enable input takes the place of an undriven service line: while it is low, the watchdog can never expire. A status flag shows whether the most recent reset came from the watchdog.

Top module: `rst_supervisor`

## Requirements
- R1: Three clock edges after `supply_ok` goes low, `sys_rst_n` is 0, and it stays 0 while `supply_ok` remains low.
- R2: Once `button_n` has been low for at least GLITCH_CYC clock cycles after synchronization, `sys_rst_n` is 0 within GLITCH_CYC+3 edges of the fall. A low pulse shorter than GLITCH_CYC cycles leaves `sys_rst_n` at 1.
- R3: `sys_rst_n` stays 0 while the supply is low or the filtered button is pressed. It returns to 1 exactly REC_CYC ticks after the last such cause goes away, plus three edges of input latency. A supply dip during recovery restarts the full interval.
- R4: If the watchdog is enabled and `wd_kick` shows no edge for WD_CYC ticks, `sys_rst_n` goes to 0 for exactly REC_CYC ticks and then returns to 1.
- R5: A rising edge or a falling edge on `wd_kick` clears the watchdog count. Toggling it more often than every WD_CYC ticks never causes a reset.
- R6: The watchdog count is held at zero while reset is active. It restarts from zero when reset is released, so the next expiry comes no sooner than WD_CYC ticks after release.
- R7: While `wd_enable` is 0, the watchdog never causes a reset, however long `wd_kick` stays constant.
- R8: `sys_rst` is always the exact inverse of `sys_rst_n`.
- R9: While `rst` is 1, `sys_rst_n` is 0 and `wd_caused` is 0 from the next edge on. After `rst` falls, `sys_rst_n` stays 0 for a full REC_CYC ticks.
- R10: `wd_caused` becomes 1 on a watchdog expiry. It returns to 0 when the next supply-low or button reset begins, or on `rst`.
- R11: The recovery and watchdog counters advance only on cycles where `tick` is 1. With `tick` held at 0, an active reset is never released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Time-base enable for the recovery and watchdog counters |
| supply_ok | input | 1 | Comparator output, 1 while the supply is above threshold (asynchronous) |
| button_n | input | 1 | Push-button line, active low (asynchronous) |
| wd_enable | input | 1 | 1 arms the watchdog, 0 holds it cleared |
| wd_kick | input | 1 | Watchdog service line, either edge counts (asynchronous) |
| sys_rst_n | output | 1 | System reset, active low (registered) |
| sys_rst | output | 1 | System reset, active high (registered) |
| wd_caused | output | 1 | 1 when the last reset came from a watchdog expiry |

## Verification
The hardest case to reach from the ports is a second watchdog expiry measured from a reset release. Showing that the count really restarts at release, and not at the earlier expiry, needs the service line held still across a whole watchdog-caused reset pulse. The bench does this by arming the watchdog with the line static. It times the gap to the first expiry, then the width of the pulse, then the gap from release to the next expiry, and checks each against WD_CYC and REC_CYC. A supply dip in the middle of recovery and a stopped `tick` are also set up on purpose, to show that the recovery interval restarts and freezes rather than running on.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int NUM_IN   = 3;
  localparam int IDX_SUP  = 0;
  localparam int IDX_BTN  = 1;
  localparam int IDX_KICK = 2;

  typedef logic [NUM_IN-1:0] raw_in_t;

  // Supply assumed good and button released after power-on; kick idles low.
  localparam raw_in_t SYNC_INIT = raw_in_t'(3'b011);
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q[i] <= INIT[i];
          sync_q[i] <= INIT[i];
        end else begin
          meta_q[i] <= d[i];
          sync_q[i] <= meta_q[i];
        end
      end
    end
  endgenerate

  assign q = sync_q;
endmodule

// File: rtl/rsv_button_filter.sv
module rsv_button_filter #(
  parameter int GLITCH_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_s,
  output logic pressed
);
  localparam int GL_W = (GLITCH_CYC < 2) ? 1 : $clog2(GLITCH_CYC + 1);
  localparam logic [GL_W-1:0] LAST = GL_W'(GLITCH_CYC - 1);

  logic [GL_W-1:0] low_cnt;
  logic            pressed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      pressed_q <= 1'b0;
    end else if (btn_s) begin
      low_cnt   <= '0;
      pressed_q <= 1'b0;
    end else if (!pressed_q) begin
      if (low_cnt == LAST) begin
        pressed_q <= 1'b1;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assign pressed = pressed_q;
endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog #(
  parameter int WD_CYC = 1600000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       enable,
  input  logic                       clear,
  input  logic                       kick_s,
  output logic                       expire,
  output logic [$clog2(WD_CYC)-1:0]  count
);
  localparam int WD_W = $clog2(WD_CYC);
  localparam logic [WD_W-1:0] LAST = WD_W'(WD_CYC - 1);

  logic            kick_d;
  logic            kick_edge;
  logic [WD_W-1:0] cnt_q;
  logic            expire_q;

  assign kick_edge = kick_s ^ kick_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      kick_d   <= 1'b0;
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      kick_d   <= kick_s;
      expire_q <= 1'b0;
      if (!enable || clear || kick_edge) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == LAST) begin
          cnt_q    <= '0;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign expire = expire_q;
  assign count  = cnt_q;
endmodule

// File: rtl/rsv_recovery.sv
module rsv_recovery #(
  parameter int REC_CYC = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  input  logic fire,
  output logic active_nxt
);
  localparam int REC_W = $clog2(REC_CYC + 1);
  localparam logic [REC_W-1:0] FULL = REC_W'(REC_CYC);

  logic [REC_W-1:0] remain_q;
  logic [REC_W-1:0] remain_nxt;

  always_comb begin
    remain_nxt = remain_q;
    if (hold || fire) begin
      remain_nxt = FULL;
    end else if (tick && (remain_q != '0)) begin
      remain_nxt = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= FULL;
    end else begin
      remain_q <= remain_nxt;
    end
  end

  assign active_nxt = (remain_nxt != '0);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int REC_CYC    = 200000,
  parameter int WD_CYC     = 1600000,
  parameter int GLITCH_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic button_n,
  input  logic wd_enable,
  input  logic wd_kick,
  output logic sys_rst_n,
  output logic sys_rst,
  output logic wd_caused
);
  localparam int WD_W = $clog2(WD_CYC);

  raw_in_t         raw_in;
  raw_in_t         syn_in;
  logic            sup_fail;
  logic            pressed;
  logic            hold;
  logic            wd_trig;
  logic [WD_W-1:0] wd_cnt;
  logic            active_nxt;
  logic            sys_rst_q;
  logic            sys_rst_n_q;
  logic            wd_caused_q;

  assign raw_in[IDX_SUP]  = supply_ok;
  assign raw_in[IDX_BTN]  = button_n;
  assign raw_in[IDX_KICK] = wd_kick;

  rsv_sync #(.W(NUM_IN), .INIT(SYNC_INIT)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign sup_fail = ~syn_in[IDX_SUP];

  rsv_button_filter #(.GLITCH_CYC(GLITCH_CYC)) u_btn (
    .clk     (clk),
    .rst     (rst),
    .btn_s   (syn_in[IDX_BTN]),
    .pressed (pressed)
  );

  rsv_watchdog #(.WD_CYC(WD_CYC)) u_wd (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .enable (wd_enable),
    .clear  (sys_rst_q),
    .kick_s (syn_in[IDX_KICK]),
    .expire (wd_trig),
    .count  (wd_cnt)
  );

  assign hold = sup_fail | pressed;

  rsv_recovery #(.REC_CYC(REC_CYC)) u_rec (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .hold       (hold),
    .fire       (wd_trig),
    .active_nxt (active_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_q   <= 1'b1;
      sys_rst_n_q <= 1'b0;
      wd_caused_q <= 1'b0;
    end else begin
      sys_rst_q   <= active_nxt;
      sys_rst_n_q <= ~active_nxt;
      if (wd_trig) begin
        wd_caused_q <= 1'b1;
      end else if (hold) begin
        wd_caused_q <= 1'b0;
      end
    end
  end

  assign sys_rst   = sys_rst_q;
  assign sys_rst_n = sys_rst_n_q;
  assign wd_caused = wd_caused_q;
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker (
  input logic clk,
  input logic rst,
  input logic sys_rst_n,
  input logic sys_rst,
  input logic wd_caused,
  input logic wd_enable,
  input logic sup_fail,
  input logic pressed,
  input logic wd_trig,
  input logic wd_idle
);
  logic rst_d = 1'b0;

  always @(posedge clk) begin
    if (rst_d) begin
      p_por_hold_r9: assert (!sys_rst_n && !wd_caused)
        else $error("R9: reset or flag wrong after power-on reset");
    end
    rst_d <= rst;
  end

  p_complement_r8: assert property (@(posedge clk) disable iff (rst)
    sys_rst == !sys_rst_n);

  p_supply_r1: assert property (@(posedge clk) disable iff (rst)
    sup_fail |=> !sys_rst_n);

  p_button_r2: assert property (@(posedge clk) disable iff (rst)
    pressed |=> !sys_rst_n);

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> $past(!sup_fail && !pressed && !wd_trig));

  p_fire_r4: assert property (@(posedge clk) disable iff (rst)
    wd_trig |=> !sys_rst_n);

  p_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    wd_trig |=> !wd_trig);

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !sys_rst_n |=> wd_idle);

  p_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    !wd_enable |=> !wd_trig);

  p_flag_r10: assert property (@(posedge clk) disable iff (rst)
    wd_trig |=> wd_caused);
endmodule

bind rst_supervisor rsv_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .sys_rst_n (sys_rst_n),
  .sys_rst   (sys_rst),
  .wd_caused (wd_caused),
  .wd_enable (wd_enable),
  .sup_fail  (sup_fail),
  .pressed   (pressed),
  .wd_trig   (wd_trig),
  .wd_idle   (wd_cnt == '0)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
  localparam int REC = 20;
  localparam int WD  = 50;
  localparam int GL  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic supply_ok = 1'b1;
  logic button_n = 1'b1;
  logic wd_enable = 1'b0;
  logic wd_kick = 1'b0;
  logic sys_rst_n;
  logic sys_rst;
  logic wd_caused;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rst_supervisor #(.REC_CYC(REC), .WD_CYC(WD), .GLITCH_CYC(GL)) dut (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok),
    .button_n(button_n), .wd_enable(wd_enable), .wd_kick(wd_kick),
    .sys_rst_n(sys_rst_n), .sys_rst(sys_rst), .wd_caused(wd_caused)
  );

  typedef struct packed {
    logic        sup;
    logic        btn;
    logic        en;
    logic        kick;
    logic [15:0] cyc;
    logic        exp_n;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd30,  1'b1},  // R9 release after POR
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'd5,   1'b0},  // R1 supply low
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd15,  1'b0},  // R3 still recovering
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd10,  1'b1},  // R3 released
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd2,   1'b1},  // R2 short glitch
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd12,  1'b1},  // R2 glitch ignored
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd12,  1'b0},  // R2 real press
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd40,  1'b0},  // R3 held while pressed
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd15,  1'b0},  // R3 recovering
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd10,  1'b1},  // R3 released
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'd30,  1'b1},  // R5 rising edge
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'd30,  1'b1},  // R5 falling edge
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'd30,  1'b1},  // R5 rising edge
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'd30,  1'b1},  // R5 falling edge
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'd120, 1'b1}   // R7 disabled, static kick
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_level(input logic lvl, input int limit, output int n);
    n = 0;
    while (sys_rst_n !== lvl && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int n;
    step(3);
    chk(sys_rst_n == 1'b0, "R9 reset state sys_rst_n", sys_rst_n, 0);
    chk(sys_rst == 1'b1, "R8 reset state sys_rst", sys_rst, 1);
    chk(wd_caused == 1'b0, "R10 reset state flag", wd_caused, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      supply_ok = TBL[i].sup;
      button_n  = TBL[i].btn;
      wd_enable = TBL[i].en;
      wd_kick   = TBL[i].kick;
      step(int'(TBL[i].cyc));
      chk(sys_rst_n == TBL[i].exp_n, $sformatf("R1-R7 table row %0d", i),
          sys_rst_n, TBL[i].exp_n);
      chk(sys_rst == ~sys_rst_n, $sformatf("R8 complement row %0d", i), sys_rst, !sys_rst_n);
    end

    // R4 first expiry with a static service line
    wd_enable = 1'b1;
    wait_level(1'b0, 200, n);
    chk(n >= WD && n <= WD + 4, "R4 expiry delay", n, WD + 1);
    chk(wd_caused == 1'b1, "R10 flag after expiry", wd_caused, 1);
    wait_level(1'b1, 200, n);
    chk(n == REC, "R4 pulse width", n, REC);
    // R6 count restarts at release
    wait_level(1'b0, 200, n);
    chk(n >= WD && n <= WD + 4, "R6 second expiry from release", n, WD + 1);
    wd_enable = 1'b0;
    wait_level(1'b1, 200, n);
    step(5);
    chk(sys_rst_n == 1'b1, "R7 stays released when disabled", sys_rst_n, 1);

    // R10 flag cleared by a supply reset
    supply_ok = 1'b0;
    step(5);
    chk(wd_caused == 1'b0, "R10 flag cleared by supply fail", wd_caused, 0);
    supply_ok = 1'b1;
    step(30);

    // R9 power-on reset mid-operation
    rst = 1'b1;
    step(1);
    chk(sys_rst_n == 1'b0, "R9 rst forces reset", sys_rst_n, 0);
    rst = 1'b0;
    wait_level(1'b1, 200, n);
    chk(n >= REC && n <= REC + 3, "R9 full interval after rst", n, REC);

    // R3 supply dip during recovery restarts the interval
    supply_ok = 1'b0;
    step(5);
    supply_ok = 1'b1;
    step(10);
    supply_ok = 1'b0;
    step(3);
    supply_ok = 1'b1;
    wait_level(1'b1, 200, n);
    chk(n >= REC + 2 && n <= REC + 5, "R3 restart after dip", n, REC + 3);

    // R11 recovery frozen without ticks
    supply_ok = 1'b0;
    step(5);
    tick = 1'b0;
    supply_ok = 1'b1;
    step(60);
    chk(sys_rst_n == 1'b0, "R11 no release without tick", sys_rst_n, 0);
    tick = 1'b1;
    step(25);
    chk(sys_rst_n == 1'b1, "R11 release once ticking", sys_rst_n, 1);
    chk(sys_rst == 1'b0, "R8 final complement", sys_rst, 0);

    summary();
  end
endmodule